// File: doc/BRIEF.md
# Flow Vector Export Window

This block publishes per-event position and flow results so a host processor can fetch them over an AXI4-Lite read port. A single-cycle pulse on the export request starts a walk over the event ring buffer. The walk begins at the ring's current read pointer and wraps at the end of the ring. For each visited event the block writes two 32-bit words into a result memory. The first word holds the normalized position and the second holds the velocity.

Once every data word is in place, the block updates an event count register. On the following cycle it increments a generation counter. A host reads the generation counter, then the data and the count, then the generation counter again. If the two generation values differ, the read overlapped an export and the host retries.

The number of events exported per generation is capped by a parameter (1024 by default). The ring size is a power of two set by its address width. Reads of count, generation and busy are served from registers, so they are never blocked behind the result memory.

Top module: `flow_export_window`

## Requirements
- R1: After reset, the count register (word offset 2·MAX_EV), the generation register (word 2·MAX_EV+1) and the busy bit (bit 0 of word 2·MAX_EV+2) all read zero.
- R2: For event i, the position word sits at byte offset 8i. It holds the unsigned 4.12 x coordinate in bits 15:0 and the unsigned 4.12 y coordinate in bits 31:16, both copied unchanged.
- R3: For event i, the velocity word sits at byte offset 8i+4. It holds the signed two's-complement 8.8 vx in bits 15:0 and vy in bits 31:16, both copied unchanged.
- R4: Entry i is taken from ring slot (read pointer + i) modulo 2^RB_AW, so the walk wraps past the last slot to slot 0.
- R5: The number of events exported equals the smaller of the ring fill level and MAX_EV. The count register reports this number, which may be zero.
- R6: Each completed export increments the generation register by exactly one. The increment comes one cycle after the count update, and no data word is written after it.
- R7: An export of n events keeps the busy bit set for 2n+2 cycles after the request edge: two cycles per event, plus one cycle for the count and one for the generation.
- R8: An export request that arrives while busy is ignored: the running export completes with its own pointer and fill, and the generation advances only once.
- R9: A read at any word offset above 2·MAX_EV+2 returns zero with an OKAY (2'b00) response. Every response is OKAY.
- R10: Only one read is outstanding at a time. ARREADY is low while RVALID is high, and RVALID and RDATA hold steady until RREADY.
- R11: During an export, the count and generation registers keep their previous values until the count step. A read of either during the walk returns the previous generation's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exp_start | input | 1 | Export request pulse |
| rb_read_ptr | input | RB_AW | Ring slot of the oldest event |
| rb_fill | input | RB_AW+1 | Number of valid events in the ring |
| rb_addr | output | RB_AW | Ring slot currently being read |
| rb_x | input | 16 | Unsigned 4.12 x of slot rb_addr |
| rb_y | input | 16 | Unsigned 4.12 y of slot rb_addr |
| rb_vx | input | 16 | Signed 8.8 vx of slot rb_addr |
| rb_vy | input | 16 | Signed 8.8 vy of slot rb_addr |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The bench builds the block with MAX_EV=8, RB_AW=4 and ADDR_W=8, so the window holds 16 words and the control registers sit at byte offsets 64, 68 and 72. With a 16-slot ring, a fill of 12 or 16 exceeds the cap, and read pointers near slot 15 force the walk to wrap. Both conditions are reached within a few dozen cycles. The small address space also lets the bench probe unmapped offsets all the way to the top of the decode range.

// File: rtl/flow_export_pkg.sv
// Shared types and helpers for the flow export window.
// Assumes 16-bit fields packed two per 32-bit word, low field first.
package flow_export_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POS,
        ST_VEL,
        ST_COUNT,
        ST_SEQ
    } exp_state_t;

    // Place the first field in bits 15:0 and the second in bits 31:16.
    function automatic logic [31:0] pack_pair(input logic [15:0] lo, input logic [15:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/flow_word_pack.sv
// Builds one result word from the ring fields of the slot being read.
// Assumes the fields are stable for both cycles spent on one event.
module flow_word_pack
    import flow_export_pkg::*;
(
    input  logic [15:0] x_q412,
    input  logic [15:0] y_q412,
    input  logic [15:0] vx_q88,
    input  logic [15:0] vy_q88,
    input  logic        sel_vel,
    output logic [31:0] word
);

    // Choose the position pair or the velocity pair.
    always_comb begin
        if (sel_vel) word = pack_pair(vx_q88, vy_q88);
        else         word = pack_pair(x_q412, y_q412);
    end

endmodule

// File: rtl/flow_win_ram.sv
// Result window storage: one write port for the sequencer, one registered
// read port for the bus slave. Contents are not reset.
module flow_win_ram #(
    parameter int DEPTH = 2048,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);

    logic [31:0] mem [DEPTH];

    // Write port driven by the export sequencer.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Registered read port; the output holds until the next read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[ridx];
    end

endmodule

// File: rtl/flow_export_seq.sv
// Export sequencer: walks the ring from the latched read pointer, writing
// two words per event, then the count, then advances the generation.
// Assumes the ring contents do not change while busy.
module flow_export_seq
    import flow_export_pkg::*;
#(
    parameter int MAX_EV = 1024,
    parameter int RB_AW = 10,
    parameter int SEQ_W = 32,
    localparam int CNT_W = $clog2(MAX_EV + 1),
    localparam int IDX_W = $clog2(2 * MAX_EV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RB_AW-1:0] read_ptr,
    input  logic [RB_AW:0]   fill,
    output logic [RB_AW-1:0] rb_addr,
    output logic             wr_en,
    output logic             wr_vel,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] count_q,
    output logic [SEQ_W-1:0] seq_q,
    output logic             busy
);

    exp_state_t       state;
    logic [RB_AW-1:0] ptr_q;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] ev_i;
    logic [CNT_W-1:0] n_new;
    logic [CNT_W-1:0] ev_next;
    logic [31:0]      fill_w;

    // Clamp the fill level to the window capacity.
    always_comb begin
        fill_w = 32'(fill);
        n_new  = (fill_w > 32'(MAX_EV)) ? CNT_W'(MAX_EV) : CNT_W'(fill_w);
    end

    assign ev_next = ev_i + CNT_W'(1);
    assign rb_addr = ptr_q + RB_AW'(ev_i);
    assign wr_en   = (state == ST_POS) || (state == ST_VEL);
    assign wr_vel  = (state == ST_VEL);
    assign wr_idx  = IDX_W'({ev_i, wr_vel});
    assign busy    = (state != ST_IDLE);

    // Export state machine with count and generation publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ptr_q   <= '0;
            n_q     <= '0;
            ev_i    <= '0;
            count_q <= '0;
            seq_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q <= read_ptr;
                        n_q   <= n_new;
                        ev_i  <= '0;
                        state <= (n_new == '0) ? ST_COUNT : ST_POS;
                    end
                end
                ST_POS: state <= ST_VEL;
                ST_VEL: begin
                    ev_i  <= ev_next;
                    state <= (ev_next == n_q) ? ST_COUNT : ST_POS;
                end
                ST_COUNT: begin
                    count_q <= n_q;
                    state   <= ST_SEQ;
                end
                ST_SEQ: begin
                    seq_q <= seq_q + SEQ_W'(1);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flow_axil_rd.sv
// AXI4-Lite read slave for the export window. One read in flight.
// Window words come from the memory; control words come from registers.
module flow_axil_rd #(
    parameter int MAX_EV = 1024,
    parameter int SEQ_W = 32,
    parameter int ADDR_W = 14,
    localparam int WIN_WORDS = 2 * MAX_EV,
    localparam int IDX_W = $clog2(WIN_WORDS),
    localparam int CNT_W = $clog2(MAX_EV + 1),
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [CNT_W-1:0]  count_q,
    input  logic [SEQ_W-1:0]  seq_q,
    input  logic              busy,
    output logic              ram_re,
    output logic [IDX_W-1:0]  ram_ridx,
    input  logic [31:0]       ram_rdata
);

    logic [WORD_W-1:0] word;
    logic [31:0]       word_w;
    logic [1:0]        addr_lsb_unused;
    logic              hs;
    logic              from_ram_q;
    logic [31:0]       reg_val;
    logic [31:0]       reg_q;

    assign word            = araddr[ADDR_W-1:2];
    assign addr_lsb_unused = araddr[1:0];
    assign word_w          = 32'(word);
    assign arready         = !rvalid;
    assign hs              = arvalid && arready;
    assign ram_re          = hs && (word_w < 32'(WIN_WORDS));
    assign ram_ridx        = IDX_W'(word);
    assign rresp           = 2'b00;
    assign rdata           = from_ram_q ? ram_rdata : reg_q;

    // Decode the control registers; anything else reads as zero.
    always_comb begin
        if (word_w == 32'(WIN_WORDS))          reg_val = 32'(count_q);
        else if (word_w == 32'(WIN_WORDS + 1)) reg_val = 32'(seq_q);
        else if (word_w == 32'(WIN_WORDS + 2)) reg_val = {31'd0, busy};
        else                                   reg_val = 32'd0;
    end

    // Response valid and source selection for the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid     <= 1'b0;
            from_ram_q <= 1'b0;
            reg_q      <= '0;
        end else if (hs) begin
            rvalid     <= 1'b1;
            from_ram_q <= ram_re;
            reg_q      <= reg_val;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/flow_export_window.sv
// Top of the flow export window: sequencer, packer, result memory and
// AXI4-Lite read slave. Assumes ring fields are combinational in rb_addr.
module flow_export_window #(
    parameter int MAX_EV = 1024,
    parameter int RB_AW = 10,
    parameter int SEQ_W = 32,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exp_start,
    input  logic [RB_AW-1:0]  rb_read_ptr,
    input  logic [RB_AW:0]    rb_fill,
    output logic [RB_AW-1:0]  rb_addr,
    input  logic [15:0]       rb_x,
    input  logic [15:0]       rb_y,
    input  logic [15:0]       rb_vx,
    input  logic [15:0]       rb_vy,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    localparam int WIN_WORDS = 2 * MAX_EV;
    localparam int IDX_W = $clog2(WIN_WORDS);
    localparam int CNT_W = $clog2(MAX_EV + 1);

    logic             wr_en;
    logic             wr_vel;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0]      wr_word;
    logic [CNT_W-1:0] count_q;
    logic [SEQ_W-1:0] seq_q;
    logic             busy;
    logic             ram_re;
    logic [IDX_W-1:0] ram_ridx;
    logic [31:0]      ram_rdata;

    flow_export_seq #(.MAX_EV(MAX_EV), .RB_AW(RB_AW), .SEQ_W(SEQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(exp_start), .read_ptr(rb_read_ptr),
        .fill(rb_fill), .rb_addr(rb_addr), .wr_en(wr_en), .wr_vel(wr_vel),
        .wr_idx(wr_idx), .count_q(count_q), .seq_q(seq_q), .busy(busy)
    );

    flow_word_pack u_pack (
        .x_q412(rb_x), .y_q412(rb_y), .vx_q88(rb_vx), .vy_q88(rb_vy),
        .sel_vel(wr_vel), .word(wr_word)
    );

    flow_win_ram #(.DEPTH(WIN_WORDS)) u_ram (
        .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(wr_word),
        .re(ram_re), .ridx(ram_ridx), .rdata(ram_rdata)
    );

    flow_axil_rd #(.MAX_EV(MAX_EV), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .araddr(s_araddr), .arvalid(s_arvalid),
        .arready(s_arready), .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid),
        .rready(s_rready), .count_q(count_q), .seq_q(seq_q), .busy(busy),
        .ram_re(ram_re), .ram_ridx(ram_ridx), .ram_rdata(ram_rdata)
    );

endmodule

// File: rtl/flow_export_window_chk.sv
// Protocol and publication-order checks for the flow export window.
module flow_export_window_chk #(
    parameter int SEQ_W = 32,
    parameter int CNT_W = 11,
    parameter int IDX_W = 11,
    parameter int WIN_WORDS = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [CNT_W-1:0] count_q,
    input logic [SEQ_W-1:0] seq_q,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             arready,
    input logic             rvalid,
    input logic             rready,
    input logic [31:0]      rdata
);

    // R6: generation only ever steps by one
    a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_q) |-> seq_q == SEQ_W'($past(seq_q) + SEQ_W'(1)));

    // R6, R11: a count update is followed at once by the generation step
    a_r11_count_then_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_q) |=> !$stable(seq_q));

    // R6: an export ends exactly when the generation advances
    a_r6_end_with_seq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$stable(seq_q));

    // R5: writes stay inside the window and only while busy
    a_r5_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (busy && (32'(wr_idx) < 32'(WIN_WORDS))));

    // R10: response held until accepted
    a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R10: no second address accepted while a response is pending
    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

endmodule

bind flow_export_window flow_export_window_chk #(
    .SEQ_W(SEQ_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .WIN_WORDS(WIN_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .count_q(count_q), .seq_q(seq_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .arready(s_arready), .rvalid(s_rvalid),
    .rready(s_rready), .rdata(s_rdata)
);

// File: tb/flow_export_window_test.sv
// Directed bench for the flow export window, one task per scenario.
module flow_export_window_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_EV = 8;
    localparam int RB_AW = 4;
    localparam int ADDR_W = 8;
    localparam int CNT_A = 8 * MAX_EV;
    localparam int SEQ_A = CNT_A + 4;
    localparam int BUSY_A = CNT_A + 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              exp_start = 1'b0;
    logic [RB_AW-1:0]  rb_read_ptr = '0;
    logic [RB_AW:0]    rb_fill = '0;
    logic [RB_AW-1:0]  rb_addr;
    logic [15:0]       rb_x, rb_y, rb_vx, rb_vy;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [31:0]       s_rdata;
    logic [1:0]        s_rresp;
    logic              s_rvalid;
    logic              s_rready = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_seq = '0;
    logic [31:0] exp_cnt = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Ring content model: fixed pattern per slot.
    function automatic logic [15:0] fx(input int s);  return 16'(16'h0400 + s * 16'h0111); endfunction
    function automatic logic [15:0] fy(input int s);  return 16'(16'hF000 - s * 16'h0203); endfunction
    function automatic logic [15:0] fvx(input int s); return 16'(s * 300 - 2000); endfunction
    function automatic logic [15:0] fvy(input int s); return 16'(500 - s * 77); endfunction

    assign rb_x  = fx(int'(rb_addr));
    assign rb_y  = fy(int'(rb_addr));
    assign rb_vx = fvx(int'(rb_addr));
    assign rb_vy = fvy(int'(rb_addr));

    flow_export_window #(.MAX_EV(MAX_EV), .RB_AW(RB_AW), .SEQ_W(32), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .exp_start(exp_start), .rb_read_ptr(rb_read_ptr),
        .rb_fill(rb_fill), .rb_addr(rb_addr), .rb_x(rb_x), .rb_y(rb_y),
        .rb_vx(rb_vx), .rb_vy(rb_vy), .s_araddr(s_araddr), .s_arvalid(s_arvalid),
        .s_arready(s_arready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One complete read; returns data and response.
    task automatic axi_read(input int addr, output logic [31:0] d, output logic [1:0] r);
        @(negedge clk);
        s_araddr  = ADDR_W'(addr);
        s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0;
        check("R10 rvalid after address", 32'(s_rvalid), 32'd1);
        d = s_rdata;
        r = s_rresp;
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic read_check(input string req, input int addr, input logic [31:0] exp);
        logic [31:0] d;
        logic [1:0]  r;
        axi_read(addr, d, r);
        check(req, d, exp);
        check("R9 response OKAY", 32'(r), 32'd0);
    endtask

    task automatic pulse_start(input int ptr, input int fill);
        @(negedge clk);
        rb_read_ptr = RB_AW'(ptr);
        rb_fill     = (RB_AW + 1)'(fill);
        exp_start   = 1'b1;
        @(negedge clk);
        exp_start   = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        logic [1:0]  r;
        for (int k = 0; k < 100; k++) begin
            axi_read(BUSY_A, d, r);
            if (d[0] == 1'b0) break;
        end
    endtask

    task automatic check_window(input int ptr, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int s = (ptr + i) % (1 << RB_AW);
            read_check({tag, " R2 R4 position word"}, 8 * i, {fy(s), fx(s)});
            read_check({tag, " R3 R4 velocity word"}, 8 * i + 4, {fvy(s), fvx(s)});
        end
    endtask

    task automatic t_reset();
        read_check("R1 count after reset", CNT_A, 32'd0);
        read_check("R1 generation after reset", SEQ_A, 32'd0);
        read_check("R1 busy after reset", BUSY_A, 32'd0);
    endtask

    task automatic t_export(input int ptr, input int fill, input string tag);
        int n = (fill > MAX_EV) ? MAX_EV : fill;
        pulse_start(ptr, fill);
        wait_idle();
        exp_seq = exp_seq + 1;
        exp_cnt = 32'(n);
        read_check({tag, " R5 count"}, CNT_A, exp_cnt);
        read_check({tag, " R6 generation"}, SEQ_A, exp_seq);
        check_window(ptr, n, tag);
    endtask

    // R7: busy covers exactly 2n+2 cycles after the request edge.
    task automatic t_timing();
        logic [31:0] d;
        logic [1:0]  r;
        int n = 3;
        @(negedge clk);
        rb_read_ptr = 4'd1;
        rb_fill     = 5'd3;
        exp_start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exp_start = 1'b0;
        repeat (2 * n + 1) @(posedge clk);
        axi_read(BUSY_A, d, r);
        check("R7 busy in last export cycle", {31'd0, d[0]}, 32'd1);
        axi_read(BUSY_A, d, r);
        check("R7 busy cleared after export", {31'd0, d[0]}, 32'd0);
        exp_seq = exp_seq + 1;
        exp_cnt = 32'(n);
        read_check("R7 generation after timed export", SEQ_A, exp_seq);
    endtask

    // R8, R11: second request during a walk is dropped; registers stay old.
    task automatic t_ignore();
        pulse_start(2, 6);
        @(negedge clk);
        rb_read_ptr = 4'd9;
        rb_fill     = 5'd2;
        exp_start   = 1'b1;
        @(negedge clk);
        exp_start   = 1'b0;
        read_check("R11 count held during export", CNT_A, exp_cnt);
        read_check("R11 generation held during export", SEQ_A, exp_seq);
        wait_idle();
        repeat (4) @(negedge clk);
        exp_seq = exp_seq + 1;
        exp_cnt = 32'd6;
        read_check("R8 generation advanced once", SEQ_A, exp_seq);
        read_check("R8 count of first request", CNT_A, exp_cnt);
        check_window(2, 6, "R8");
    endtask

    task automatic t_unmapped();
        read_check("R9 first unmapped word", BUSY_A + 4, 32'd0);
        read_check("R9 mid unmapped word", 160, 32'd0);
        read_check("R9 top of decode range", 252, 32'd0);
    endtask

    // R10: stalled response holds; a waiting address is taken only after drain.
    task automatic t_stall();
        logic [31:0] first;
        @(negedge clk);
        s_araddr  = ADDR_W'(SEQ_A);
        s_arvalid = 1'b1;
        @(negedge clk);
        s_araddr  = ADDR_W'(CNT_A);
        first = s_rdata;
        check("R10 first data", first, exp_seq);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 rvalid held", 32'(s_rvalid), 32'd1);
            check("R10 arready low", 32'(s_arready), 32'd0);
            check("R10 rdata stable", s_rdata, first);
        end
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
        check("R10 response drained", 32'(s_rvalid), 32'd0);
        @(negedge clk);
        s_arvalid = 1'b0;
        check("R10 second read valid", 32'(s_rvalid), 32'd1);
        check("R10 second read data", s_rdata, exp_cnt);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_export(0, 3, "plain");
        t_export(13, 5, "wrap");
        t_export(6, 12, "cap");
        t_export(10, 16, "full-wrap");
        t_export(4, 0, "empty");
        t_timing();
        t_ignore();
        t_unmapped();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule